// File: doc/BRIEF.md
# Virtqueue Descriptor Chain Walker

This block serves one virtqueue in a paravirtual device. Software hands it the page frame number of the queue, and from that single number it works out where the descriptor table, the available ring and the used ring sit in guest memory. On each command it first reads the guest's published available index. For a get command it then fetches the head descriptor index from the available ring and follows the linked list of descriptors. Each descriptor is reported as one segment: an address and length pair, marked as device-writable (in) or device-readable (out), and numbered within its own list. A skip command only steps past one available entry and reads no descriptors.

All guest memory traffic goes through a single read port. The port has a valid/ready request channel and a response that has no handshake. The walker keeps at most one read in flight and waits as long as the response takes. Segments leave on a valid/ready stream. While `seg_ready` is low, the offered segment stays unchanged, and the walker issues no further reads. Descriptors that come from an untrusted guest may link into a loop. For that reason a chain is cut off once it has produced as many segments as the ring has slots. The cut is reported as a one-cycle pulse on `loop_abort`.

Top module: `vq_chain_walker`

## Requirements
- R1: On a write of a non-zero page number P, the descriptor base is P shifted left by PAGE_SHIFT. The available base is that value plus 16 × RING_SIZE. The used base is the available base plus 4 + 2 × RING_SIZE, rounded up to the next multiple of the page size.
- R2: Every ring slot index is taken modulo RING_SIZE before an address is formed. This covers the head descriptor index, every next-link value, and the next-available index used to address the available ring. Available entry k is the 16-bit value at available base + 4 + 2 × (k mod RING_SIZE). Descriptor d starts at descriptor base + 16 × (d mod RING_SIZE).
- R3: The queue is empty when the guest's 16-bit index at available base + 2 equals `next_avail`. A get or a skip on an empty queue ends with `op_done` high and `op_ok` low. It emits no segment and leaves `next_avail` unchanged.
- R4: A successful get (`cmd_skip`=0) reports the head index on `seg_head` of every segment of the chain. It advances `next_avail` by one only when `cmd_remove` is high.
- R5: A successful skip (`cmd_skip`=1) advances `next_avail` by one and issues exactly one memory read, the one for the guest index.
- R6: A descriptor is 16 little-endian bytes: address at bytes 0–7, length at bytes 8–11, flags at bytes 12–13 and next link at bytes 14–15. Flag bit 1 set gives an in segment (`seg_dev_wr`=1); otherwise the segment is out. `seg_idx` counts in and out segments separately, each starting at 0 on every get.
- R7: The walk follows the next link while flag bit 0 is set. The segment from a descriptor with bit 0 clear carries `seg_last`=1 and completes the get with `op_ok`=1.
- R8: A chain ends after exactly RING_SIZE segments even if the chain flag is still set. That segment carries `seg_last`, and `loop_abort` pulses in the same cycle as `op_done`.
- R9: Reset clears all three bases and `next_avail`. Any page-number write sets `next_avail` to 0, and a write of 0 clears all three bases.
- R10: A segment offered while `seg_ready` is low stays valid and unchanged until accepted. A memory request stays valid with the same address until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfn_wr | input | 1 | Load a new page number (only while `cmd_ready`) |
| pfn_in | input | PFN_W | Page frame number of the queue |
| desc_base | output | 64 | Descriptor table base address |
| avail_base | output | 64 | Available ring base address |
| used_base | output | 64 | Used ring base address |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Walker idle; command accepted when both high |
| cmd_skip | input | 1 | 1 = skip, 0 = get |
| cmd_remove | input | 1 | For get: consume the available entry |
| op_done | output | 1 | One-cycle pulse when a command ends |
| op_ok | output | 1 | Valid with `op_done`; 0 = queue empty |
| loop_abort | output | 1 | Pulse: chain cut at the segment limit |
| next_avail | output | 16 | Device next-available index |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read byte address |
| mem_req_bytes | output | 4 | Read size in bytes (2 or 8) |
| mem_rsp_valid | input | 1 | Read data valid, one cycle, after acceptance |
| mem_rsp_data | input | 64 | Little-endian read data, zero-extended |
| seg_valid | output | 1 | Segment valid |
| seg_ready | input | 1 | Segment accepted |
| seg_addr | output | 64 | Segment buffer address |
| seg_len | output | 32 | Segment length in bytes |
| seg_dev_wr | output | 1 | 1 = in (device-writable) segment |
| seg_idx | output | CNT_W | Position within its in or out list |
| seg_head | output | 16 | Head descriptor index of the chain |
| seg_last | output | 1 | Final segment of the chain |

## Verification
The hardest case to reach from the ports is the segment limit. It needs a guest memory image whose descriptors link back on themselves, with both flag kinds in the loop, so that both list counters climb together. The bench builds a two-descriptor cycle in which one next link is larger than the ring size, so the link is folded by the modulo. It then checks that exactly RING_SIZE segments come out with alternating lists, and that the abort pulse lands with the completion. The modulo on the available ring is reached by issuing a run of skips that carries the next-available index past the ring size. Random stalls on both the memory port and the segment stream test that data is held steady.

// File: rtl/vqw_pkg.sv
package vqw_pkg;
  localparam int unsigned ADDR_W      = 64;
  localparam int unsigned DESC_BYTES  = 16;
  localparam int unsigned AVAIL_HDR   = 4;
  localparam int unsigned AIDX_OFS    = 2;
  localparam int unsigned LEN_LSB     = 0;
  localparam int unsigned FLAG_LSB    = 32;
  localparam int unsigned LINK_LSB    = 48;
  localparam int unsigned CHAIN_BIT   = 0;
  localparam int unsigned DEVWR_BIT   = 1;

  typedef enum logic [2:0] {
    W_IDLE, W_AIDX, W_HEAD, W_DLO, W_DHI, W_EMIT
  } walk_st_t;
endpackage

// File: rtl/vqw_layout.sv
module vqw_layout
  import vqw_pkg::*;
#(
  parameter int unsigned PFN_W      = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned RING_SIZE  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfn_wr,
  input  logic [PFN_W-1:0]  pfn_in,
  output logic [ADDR_W-1:0] desc_base,
  output logic [ADDR_W-1:0] avail_base,
  output logic [ADDR_W-1:0] used_base
);
  localparam logic [ADDR_W-1:0] TABLE_SPAN = ADDR_W'(RING_SIZE * DESC_BYTES);
  localparam logic [ADDR_W-1:0] AVAIL_SPAN = ADDR_W'(AVAIL_HDR + 2 * RING_SIZE);
  localparam logic [ADDR_W-1:0] PAGE_MASK  = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

  logic [ADDR_W-1:0] nd, na, nu;

  always_comb begin
    nd = ADDR_W'(pfn_in) << PAGE_SHIFT;
    na = nd + TABLE_SPAN;
    nu = (na + AVAIL_SPAN + PAGE_MASK) & ~PAGE_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (pfn_wr && pfn_in == '0)) begin
      desc_base  <= '0;
      avail_base <= '0;
      used_base  <= '0;
    end else if (pfn_wr) begin
      desc_base  <= nd;
      avail_base <= na;
      used_base  <= nu;
    end
  end

  // R1
  used_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_base != '0) |-> ((used_base >= avail_base + AVAIL_SPAN) &&
                           ((used_base & PAGE_MASK) == '0)));
endmodule

// File: rtl/vqw_walker.sv
module vqw_walker
  import vqw_pkg::*;
#(
  parameter  int unsigned RING_SIZE = 8,
  localparam int unsigned CNT_W     = $clog2(RING_SIZE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] avail_base,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_skip,
  input  logic              cmd_remove,
  output logic              op_done,
  output logic              op_ok,
  output logic              loop_abort,
  output logic [15:0]       next_avail,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [3:0]        mem_req_bytes,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [63:0]       seg_addr,
  output logic [31:0]       seg_len,
  output logic              seg_dev_wr,
  output logic [CNT_W-1:0]  seg_idx,
  output logic [15:0]       seg_head,
  output logic              seg_last
);
  localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(RING_SIZE);

  walk_st_t         st;
  logic             waiting, op_skip, op_rm;
  logic [15:0]      head, cur;
  logic [CNT_W-1:0] n_in, n_out;
  logic [CNT_W:0]   total;
  logic [63:0]      d_addr;
  logic [31:0]      d_len;
  logic             d_wr, d_chain;
  logic [15:0]      d_link;

  function automatic logic [ADDR_W-1:0] slot_of(input logic [15:0] idx);
    return ADDR_W'(32'(idx) % RING_SIZE);
  endfunction

  assign total     = {1'b0, n_in} + {1'b0, n_out};
  assign cmd_ready = (st == W_IDLE);
  assign seg_valid = (st == W_EMIT);
  assign seg_addr  = d_addr;
  assign seg_len   = d_len;
  assign seg_dev_wr = d_wr;
  assign seg_idx   = d_wr ? n_in : n_out;
  assign seg_head  = head;
  assign seg_last  = !d_chain || ((total + (CNT_W + 1)'(1)) >= LIMIT);

  always_comb begin
    mem_req_valid = !waiting && (st inside {W_AIDX, W_HEAD, W_DLO, W_DHI});
    mem_req_addr  = '0;
    mem_req_bytes = 4'd8;
    case (st)
      W_AIDX: begin
        mem_req_addr  = avail_base + ADDR_W'(AIDX_OFS);
        mem_req_bytes = 4'd2;
      end
      W_HEAD: begin
        mem_req_addr  = avail_base + ADDR_W'(AVAIL_HDR) + (slot_of(next_avail) << 1);
        mem_req_bytes = 4'd2;
      end
      W_DLO:   mem_req_addr = desc_base + slot_of(cur) * ADDR_W'(DESC_BYTES);
      W_DHI:   mem_req_addr = desc_base + slot_of(cur) * ADDR_W'(DESC_BYTES) + ADDR_W'(8);
      default: mem_req_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE; waiting <= 1'b0; op_skip <= 1'b0; op_rm <= 1'b0;
      head <= '0; cur <= '0; n_in <= '0; n_out <= '0;
      d_addr <= '0; d_len <= '0; d_wr <= 1'b0; d_chain <= 1'b0; d_link <= '0;
      next_avail <= '0; op_done <= 1'b0; op_ok <= 1'b0; loop_abort <= 1'b0;
    end else begin
      op_done    <= 1'b0;
      op_ok      <= 1'b0;
      loop_abort <= 1'b0;
      if (mem_req_valid && mem_req_ready) waiting <= 1'b1;
      case (st)
        W_IDLE: begin
          if (clr) next_avail <= '0;
          if (cmd_valid) begin
            op_skip <= cmd_skip;
            op_rm   <= cmd_remove;
            st      <= W_AIDX;
          end
        end
        W_AIDX: if (waiting && mem_rsp_valid) begin
          waiting <= 1'b0;
          if (mem_rsp_data[15:0] == next_avail) begin
            op_done <= 1'b1;
            st      <= W_IDLE;
          end else if (op_skip) begin
            next_avail <= next_avail + 16'd1;
            op_done    <= 1'b1;
            op_ok      <= 1'b1;
            st         <= W_IDLE;
          end else begin
            st <= W_HEAD;
          end
        end
        W_HEAD: if (waiting && mem_rsp_valid) begin
          waiting <= 1'b0;
          head    <= mem_rsp_data[15:0];
          cur     <= mem_rsp_data[15:0];
          n_in    <= '0;
          n_out   <= '0;
          if (op_rm) next_avail <= next_avail + 16'd1;
          st <= W_DLO;
        end
        W_DLO: if (waiting && mem_rsp_valid) begin
          waiting <= 1'b0;
          d_addr  <= mem_rsp_data;
          st      <= W_DHI;
        end
        W_DHI: if (waiting && mem_rsp_valid) begin
          waiting <= 1'b0;
          d_len   <= mem_rsp_data[LEN_LSB +: 32];
          d_chain <= mem_rsp_data[FLAG_LSB + CHAIN_BIT];
          d_wr    <= mem_rsp_data[FLAG_LSB + DEVWR_BIT];
          d_link  <= mem_rsp_data[LINK_LSB +: 16];
          st      <= W_EMIT;
        end
        W_EMIT: if (seg_ready) begin
          if (d_wr) n_in  <= n_in + CNT_W'(1);
          else      n_out <= n_out + CNT_W'(1);
          if (seg_last) begin
            op_done    <= 1'b1;
            op_ok      <= 1'b1;
            loop_abort <= d_chain;
            st         <= W_IDLE;
          end else begin
            cur <= d_link;
            st  <= W_DLO;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R10
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len) &&
                                   $stable(seg_dev_wr) && $stable(seg_idx)));
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R8
  seg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total <= LIMIT);
  // R8
  abort_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_abort |-> (op_done && op_ok));
  // R3
  empty_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !op_ok) |-> (next_avail == $past(next_avail)));
  // R5
  skip_nodesc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {W_HEAD, W_DLO, W_DHI, W_EMIT}) |-> !op_skip);
endmodule

// File: rtl/vq_chain_walker.sv
module vq_chain_walker
  import vqw_pkg::*;
#(
  parameter  int unsigned PFN_W      = 32,
  parameter  int unsigned PAGE_SHIFT = 12,
  parameter  int unsigned RING_SIZE  = 8,
  localparam int unsigned CNT_W      = $clog2(RING_SIZE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfn_wr,
  input  logic [PFN_W-1:0]  pfn_in,
  output logic [63:0]       desc_base,
  output logic [63:0]       avail_base,
  output logic [63:0]       used_base,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_skip,
  input  logic              cmd_remove,
  output logic              op_done,
  output logic              op_ok,
  output logic              loop_abort,
  output logic [15:0]       next_avail,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  output logic [3:0]        mem_req_bytes,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [63:0]       seg_addr,
  output logic [31:0]       seg_len,
  output logic              seg_dev_wr,
  output logic [CNT_W-1:0]  seg_idx,
  output logic [15:0]       seg_head,
  output logic              seg_last
);
  vqw_layout #(.PFN_W(PFN_W), .PAGE_SHIFT(PAGE_SHIFT), .RING_SIZE(RING_SIZE)) u_layout (
    .clk(clk), .rst_n(rst_n), .pfn_wr(pfn_wr), .pfn_in(pfn_in),
    .desc_base(desc_base), .avail_base(avail_base), .used_base(used_base)
  );

  vqw_walker #(.RING_SIZE(RING_SIZE)) u_walker (
    .clk(clk), .rst_n(rst_n), .clr(pfn_wr),
    .desc_base(desc_base), .avail_base(avail_base),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_skip(cmd_skip), .cmd_remove(cmd_remove),
    .op_done(op_done), .op_ok(op_ok), .loop_abort(loop_abort), .next_avail(next_avail),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_bytes(mem_req_bytes),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_dev_wr(seg_dev_wr), .seg_idx(seg_idx), .seg_head(seg_head), .seg_last(seg_last)
  );
endmodule

// File: tb/sim_vq_chain_walker.sv
`timescale 1ns/1ps
module sim_vq_chain_walker;
  localparam int RS = 8;
  localparam int CW = $clog2(RS + 1);

  typedef struct packed {
    logic [63:0] addr; logic [31:0] len; logic wr; logic [CW-1:0] idx; logic [15:0] head; logic last;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic pfn_wr = 0; logic [31:0] pfn_in = 0;
  logic [63:0] desc_base, avail_base, used_base;
  logic cmd_valid = 0, cmd_ready, cmd_skip = 0, cmd_remove = 0;
  logic op_done, op_ok, loop_abort; logic [15:0] next_avail;
  logic mem_req_valid, mem_req_ready = 0; logic [63:0] mem_req_addr; logic [3:0] mem_req_bytes;
  logic mem_rsp_valid = 0; logic [63:0] mem_rsp_data = 0;
  logic seg_valid, seg_ready = 0; logic [63:0] seg_addr; logic [31:0] seg_len;
  logic seg_dev_wr; logic [CW-1:0] seg_idx; logic [15:0] seg_head; logic seg_last;

  always #2.5 clk = ~clk;

  vq_chain_walker #(.RING_SIZE(RS)) u0 (.*);

  int total = 0, bad = 0;
  logic [7:0] gmem [logic [63:0]];
  exp_t exp_q[$];
  logic [63:0] m_desc, m_avail;
  logic [15:0] m_next;
  int req_count = 0;
  bit done_seen, done_ok_v, abort_seen, exp_ok, exp_abort;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr_mem(input logic [63:0] a, input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) gmem[a + 64'(i)] = v[8*i +: 8];
  endtask

  function automatic logic [63:0] rd_mem(input logic [63:0] a, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++)
      if (gmem.exists(a + 64'(i))) v[8*i +: 8] = gmem[a + 64'(i)];
    return v;
  endfunction

  task automatic put_desc(input int d, input logic [63:0] addr, input logic [31:0] len,
                          input logic [15:0] flags, input logic [15:0] link);
    wr_mem(m_desc + 64'(16 * d), addr, 8);
    wr_mem(m_desc + 64'(16 * d + 8), {link, flags, len}, 8);
  endtask

  // memory responder
  initial begin
    int lat = -1; logic [63:0] pend = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (lat == 0) begin mem_rsp_valid = 1; mem_rsp_data = pend; lat = -1; end
      else if (lat > 0) lat--;
      mem_req_ready = ($urandom_range(0, 3) != 0);
      #1;
      if (mem_req_valid && mem_req_ready) begin
        pend = rd_mem(mem_req_addr, int'(mem_req_bytes));
        lat = $urandom_range(0, 2);
        req_count++;
      end
    end
  end

  // segment monitor / scoreboard
  initial begin
    bit stall = 0; exp_t held, got, e;
    forever begin
      @(negedge clk);
      seg_ready = ($urandom_range(0, 2) != 0);
      #1;
      got = '{seg_addr, seg_len, seg_dev_wr, seg_idx, seg_head, seg_last};
      if (stall) check(seg_valid && got == held, "R10 segment held", got[63:0], held[63:0]);
      stall = seg_valid && !seg_ready;
      held = got;
      if (seg_valid && seg_ready) begin
        if (exp_q.size() == 0) check(0, "R6 unexpected segment", got[63:0], 0);
        else begin
          e = exp_q.pop_front();
          check(got == e, "R6/R7 segment", {got.addr[31:0], got.len[15:0], 3'b0, got.wr, 3'b0, got.last, 4'(got.idx), got.head[3:0]},
                {e.addr[31:0], e.len[15:0], 3'b0, e.wr, 3'b0, e.last, 4'(e.idx), e.head[3:0]});
        end
      end
      if (op_done) begin done_seen = 1; done_ok_v = op_ok; end
      if (loop_abort) abort_seen = 1;
    end
  end

  // expected behaviour built from the requirements
  task automatic model(input bit skip, input bit rm);
    logic [15:0] gidx, cur; int cnt = 0, nin = 0, nout = 0;
    logic [63:0] lo, hi; bit chain, last;
    exp_abort = 0;
    gidx = 16'(rd_mem(m_avail + 2, 2));
    if (gidx == m_next) begin exp_ok = 0; return; end
    exp_ok = 1;
    if (skip) begin m_next++; return; end
    cur = 16'(rd_mem(m_avail + 4 + 64'(2 * (m_next % RS)), 2));
    begin
      logic [15:0] hd = cur;
      if (rm) m_next++;
      forever begin
        lo = rd_mem(m_desc + 64'(16 * (cur % RS)), 8);
        hi = rd_mem(m_desc + 64'(16 * (cur % RS) + 8), 8);
        chain = hi[32];
        last = !chain || (cnt + 1 >= RS);
        exp_q.push_back('{lo, hi[31:0], hi[33], hi[33] ? CW'(nin) : CW'(nout), hd, last});
        if (hi[33]) nin++; else nout++;
        cnt++;
        if (last) begin exp_abort = chain; break; end
        cur = hi[63:48];
      end
    end
  endtask

  task automatic run_cmd(input bit skip, input bit rm, input string tag);
    int r0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    model(skip, rm);
    done_seen = 0; abort_seen = 0; r0 = req_count;
    cmd_valid = 1; cmd_skip = skip; cmd_remove = rm;
    @(negedge clk);
    cmd_valid = 0;
    while (!done_seen) @(negedge clk);
    @(negedge clk); #2;
    check(done_ok_v == exp_ok, {tag, " op_ok"}, done_ok_v, exp_ok);
    check(abort_seen == exp_abort, {tag, " loop_abort"}, abort_seen, exp_abort);
    check(next_avail == m_next, {tag, " next_avail"}, next_avail, m_next);
    check(exp_q.size() == 0, {tag, " segments left"}, exp_q.size(), 0);
    if (skip || !exp_ok) check(req_count - r0 == 1, {tag, " reads"}, req_count - r0, 1);
  endtask

  task automatic load_pfn(input logic [31:0] p);
    @(negedge clk); while (!cmd_ready) @(negedge clk);
    pfn_wr = 1; pfn_in = p;
    @(negedge clk); pfn_wr = 0;
    m_next = 0;
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_next = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(desc_base == 0 && avail_base == 0 && used_base == 0, "R9 reset bases", desc_base | avail_base | used_base, 0);
    check(next_avail == 0 && cmd_ready && !seg_valid && !op_done, "R9 reset idle", next_avail, 0);

    load_pfn(32'h1);
    m_desc = 64'h1000; m_avail = 64'h1080;
    // R1 layout
    check(desc_base == 64'h1000, "R1 desc base", desc_base, 64'h1000);
    check(avail_base == 64'h1080, "R1 avail base", avail_base, 64'h1080);
    check(used_base == 64'h2000, "R1 used base", used_base, 64'h2000);

    put_desc(1, 64'hA100, 32'h40, 16'h0, 16'h0);
    put_desc(5, 64'hA500, 32'h100, 16'h1, 16'h2);
    put_desc(2, 64'hA200, 32'h200, 16'h3, 16'h7);
    put_desc(7, 64'hA700, 32'h80, 16'h2, 16'h0);
    put_desc(3, 64'hA300, 32'h10, 16'h1, 16'h4);
    put_desc(4, 64'hA400, 32'h20, 16'h3, 16'd11);
    wr_mem(m_avail + 4, 5, 2);
    wr_mem(m_avail + 6, 1, 2);
    wr_mem(m_avail + 8, 3, 2);
    wr_mem(m_avail + 10, 13, 2);
    wr_mem(m_avail + 2, 0, 2);

    run_cmd(0, 1, "R3 empty get");
    wr_mem(m_avail + 2, 4, 2);
    run_cmd(0, 1, "R6 R7 mixed chain");
    run_cmd(0, 0, "R4 peek");
    run_cmd(0, 0, "R4 peek again");
    run_cmd(1, 0, "R5 skip");
    run_cmd(0, 1, "R8 looped chain");
    run_cmd(0, 1, "R2 head modulo");
    run_cmd(0, 1, "R3 empty get after drain");
    run_cmd(1, 0, "R3 empty skip");
    wr_mem(m_avail + 2, 12, 2);
    for (int i = 0; i < 5; i++) run_cmd(1, 0, "R5 skip run");
    run_cmd(0, 1, "R2 avail modulo");

    load_pfn(32'h0);
    check(desc_base == 0 && avail_base == 0 && used_base == 0, "R9 zero pfn bases", desc_base, 0);
    check(next_avail == 0, "R9 zero pfn index", next_avail, 0);
    load_pfn(32'h3);
    check(desc_base == 64'h3000 && avail_base == 64'h3080, "R1 second page", avail_base, 64'h3080);
    check(used_base == 64'h4000, "R1 second used", used_base, 64'h4000);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule